// File: doc/BRIEF.md
# Width-Aware Almost-Empty Flag Generator

This block drives the active-low almost-empty indication for one queue whose writer and reader run on unrelated clocks. The writer counts whole write words in its own domain and sends that count to the read side as a Gray code. The read side converts the synchronised count into 9-bit quarter-word units, scaled by the configured write width. It subtracts its own read position, also kept in quarter-word units, and compares the occupancy against a threshold. The threshold depends on the captured offset, on whether the read port is attached to the queue, and on whether the read port is full width.

The offset and both port widths are straps. The block captures them on the first read-clock edge after reset is released. While the read side is switching queues, the output holds its current value for one extra read clock. The storage array, queue selection logic and all other flags sit outside this block.

Top module: `aef_top`

## Requirements
- R1: While rst_ni is low, and after its release until enough words are written, `almost_empty_no` is 0.
- R2: The offset n is captured on the first read-clock edge after reset: 8 when `def_sel_i` is 0, 128 when it is 1.
- R3: Width code in `wr_width_i`/`rd_width_i`: 0 = 36 bits, 1 = 18 bits, 2 or 3 = 9 bits. With a 36-bit writer, a 36-bit reader and `rd_sel_i` = 1, the flag goes high once n+2 words have been written.
- R4: With a 36-bit writer, an 18-bit or 9-bit reader and `rd_sel_i` = 1, the flag goes high once n+1 words have been written.
- R5: With a 36-bit reader and `rd_sel_i` = 1, an 18-bit writer needs (n+2)×2 writes and a 9-bit writer needs (n+2)×4 writes before the flag goes high.
- R6: With `rd_sel_i` = 0, the flag goes high after (n+1) writes for a 36-bit writer, (n+1)×2 for an 18-bit writer and (n+1)×4 for a 9-bit writer. Reads are ignored while `rd_sel_i` is 0.
- R7: A read that lowers the occupancy below the threshold drives the flag low after the second read-clock edge following the read edge.
- R8: A write that reaches the threshold raises the flag after SYNC_STAGES+2 read-clock edges, counted from the first read edge after the write edge.
- R9: While `rd_switch_i` is 1 at a read-clock edge, the flag holds its value, so a pending change is delayed by one read clock.
- R10: A read is ignored when the occupancy is smaller than one read word. The flag is low whenever the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| def_sel_i | input | 1 | Offset strap: 0 selects 8, 1 selects 128 |
| wr_width_i | input | 2 | Write port width code (strap) |
| rd_width_i | input | 2 | Read port width code (strap) |
| wr_en_i | input | 1 | One write word per write-clock edge |
| rd_en_i | input | 1 | One read word per read-clock edge |
| rd_sel_i | input | 1 | Read port attached to this queue |
| rd_switch_i | input | 1 | Read side is switching queues this cycle |
| almost_empty_no | output | 1 | Low when the occupancy is below the threshold |

## Verification
A read that would drop the flag can land on the same read clock as a queue switch. To provoke this, the bench raises `rd_switch_i` for exactly the edge at which the drop would appear. The check then expects the flag still high after that edge and low one read clock later. The write-side rise is judged separately by counting read edges from a fixed phase offset between the two clocks. Every width pairing is run with both offset defaults, and the expected write count is computed arithmetically.

// File: rtl/aef_pkg.sv
package aef_pkg;
  // shift giving quarter-word units per word: 36->2, 18->1, 9->0
  function automatic logic [1:0] unit_shift(input logic [1:0] code);
    case (code)
      2'd0:    unit_shift = 2'd2;
      2'd1:    unit_shift = 2'd1;
      default: unit_shift = 2'd0;
    endcase
  endfunction

  function automatic logic [11:0] gray_to_bin(input logic [11:0] g);
    logic [11:0] b;
    b[11] = g[11];
    for (int i = 10; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/aef_wr_ptr.sv
module aef_wr_ptr #(
  parameter int PTR_W = 12
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  output logic [PTR_W-1:0] gray_o
);
  logic [PTR_W-1:0] bin_q, bin_nx;

  assign bin_nx = bin_q + PTR_W'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else if (wr_en_i) begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end

  AST_GRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) <= 1); // R8
endmodule

// File: rtl/aef_sync.sv
module aef_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  AST_SYNC_ONEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q_o ^ $past(q_o)) <= 1); // R8
endmodule

// File: rtl/aef_rd_flag.sv
module aef_rd_flag
  import aef_pkg::*;
#(
  parameter int PTR_W = 12,
  parameter int N_LO  = 8,
  parameter int N_HI  = 128
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] wgray_i,
  input  logic             def_sel_i,
  input  logic [1:0]       wr_width_i,
  input  logic [1:0]       rd_width_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  input  logic             rd_switch_i,
  output logic             flag_o
);
  logic             cfg_done_q;
  logic [PTR_W-1:0] n_q;
  logic [1:0]       wsh_q, rsh_q;
  logic [PTR_W-1:0] rptr_q, wunits, level, ru, thr;
  logic             rd_ok, above_q;

  // straps captured on first edge after reset
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      n_q        <= '0;
      wsh_q      <= '0;
      rsh_q      <= '0;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      n_q        <= def_sel_i ? PTR_W'(N_HI) : PTR_W'(N_LO);
      wsh_q      <= unit_shift(wr_width_i);
      rsh_q      <= unit_shift(rd_width_i);
    end
  end

  assign wunits = gray_to_bin(wgray_i) << wsh_q;
  assign level  = wunits - rptr_q;
  assign ru     = PTR_W'(1) << rsh_q;
  assign thr    = (n_q + ((rsh_q == 2'd2 && rd_sel_i) ? PTR_W'(2) : PTR_W'(1))) << 2;
  assign rd_ok  = rd_en_i && rd_sel_i && cfg_done_q && (level >= ru);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      above_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      if (rd_ok) rptr_q <= rptr_q + ru;
      above_q <= cfg_done_q && (level >= thr);
      if (!rd_switch_i) flag_o <= above_q;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && level < ru) |=> $stable(rptr_q)); // R10
  AST_DESEL_NO_READ: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_sel_i) |=> $stable(rptr_q)); // R6
  AST_EMPTY_LOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (level == '0) |=> !above_q); // R10
  AST_SWITCH_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_switch_i |=> $stable(flag_o)); // R9
  AST_CFG_STABLE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    cfg_done_q |=> ($stable(n_q) && $stable(wsh_q) && $stable(rsh_q))); // R2
  AST_UNCONF_LOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !cfg_done_q |-> !flag_o); // R1
endmodule

// File: rtl/aef_top.sv
module aef_top #(
  parameter int PTR_W       = 12,
  parameter int N_LO        = 8,
  parameter int N_HI        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       def_sel_i,
  input  logic [1:0] wr_width_i,
  input  logic [1:0] rd_width_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic       rd_sel_i,
  input  logic       rd_switch_i,
  output logic       almost_empty_no
);
  logic [PTR_W-1:0] wgray, wgray_s;

  aef_wr_ptr #(.PTR_W(PTR_W)) u_wr (
    .wclk_i (wclk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .gray_o (wgray)
  );

  aef_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  aef_rd_flag #(.PTR_W(PTR_W), .N_LO(N_LO), .N_HI(N_HI)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .wgray_i    (wgray_s),
    .def_sel_i  (def_sel_i),
    .wr_width_i (wr_width_i),
    .rd_width_i (rd_width_i),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .rd_switch_i(rd_switch_i),
    .flag_o     (almost_empty_no)
  );

  AST_RESET_LOW: assert property (@(posedge rclk_i) !rst_ni |-> !almost_empty_no); // R1
endmodule

// File: tb/sim_aef_top.sv
module sim_aef_top;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic def_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b1, rd_sw = 1'b0;
  logic [1:0] wr_w = 2'd0, rd_w = 2'd0;
  logic flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial begin #5; forever #10 wclk = ~wclk; end
  initial begin #10; forever #10 rclk = ~rclk; end

  aef_top u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .def_sel_i(def_sel),
    .wr_width_i(wr_w), .rd_width_i(rd_w), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rd_sel_i(rd_sel), .rd_switch_i(rd_sw), .almost_empty_no(flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s flag act=%0b exp=%0b (wr=%0d rd=%0d sel=%0b def=%0b)",
               req, act, exp, wr_w, rd_w, rd_sel, def_sel);
    end
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic run_cfg(input logic ds, input logic [1:0] ww, input logic [1:0] rw,
                         input logic sel, input bit sw_case);
    int n, t, k, wu, ru;
    n  = ds ? 128 : 8;
    wu = (ww == 2'd0) ? 4 : (ww == 2'd1) ? 2 : 1;
    ru = (rw == 2'd0) ? 4 : (rw == 2'd1) ? 2 : 1;
    t  = 4 * (n + ((rw == 2'd0 && sel) ? 2 : 1));
    k  = t / wu;
    rst_n = 1'b0; def_sel = ds; wr_w = ww; rd_w = rw; rd_sel = sel;
    #3; chk("R1", flag, 1'b0);
    wait_r(2); rst_n = 1'b1;
    wait_r(4); chk("R1", flag, 1'b0);
    // k-1 writes, still below threshold
    @(negedge wclk); wr_en = 1'b1;
    repeat (k - 1) @(negedge wclk);
    wr_en = 1'b0;
    wait_r(8);
    chk(sel ? ((rw == 2'd0) ? ((ww == 2'd0) ? "R3" : "R5") : "R4") : "R6", flag, 1'b0);
    chk("R2", flag, 1'b0);
    // final write; rise after SYNC_STAGES+2 = 4 read edges
    @(negedge wclk); wr_en = 1'b1;
    @(posedge wclk); #1 wr_en = 1'b0;
    wait_r(3); chk("R8", flag, 1'b0);
    wait_r(1); chk("R8", flag, 1'b1);
    chk(sel ? ((rw == 2'd0) ? ((ww == 2'd0) ? "R3" : "R5") : "R4") : "R6", flag, 1'b1);
    chk("R2", flag, 1'b1);
    if (sel) begin
      @(negedge rclk); rd_en = 1'b1;
      @(posedge rclk); #1 rd_en = 1'b0;
      if (sw_case) begin
        @(posedge rclk); @(negedge rclk); rd_sw = 1'b1;
        @(posedge rclk); #1 rd_sw = 1'b0;
        @(negedge rclk); chk("R9", flag, 1'b1);
        wait_r(1); chk("R9", flag, 1'b0);
      end else begin
        wait_r(1); chk("R7", flag, 1'b1);
        wait_r(1); chk("R7", flag, 1'b0);
      end
    end else begin
      @(negedge rclk); rd_en = 1'b1;
      repeat (4) @(negedge rclk);
      rd_en = 1'b0;
      wait_r(6); chk("R6", flag, 1'b1);
    end
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      run_cfg(d[0], 2'd0, 2'd0, 1'b1, d == 0);
      run_cfg(d[0], 2'd0, 2'd1, 1'b1, 0);
      run_cfg(d[0], 2'd0, 2'd2, 1'b1, 0);
      run_cfg(d[0], 2'd1, 2'd0, 1'b1, d == 1);
      run_cfg(d[0], 2'd2, 2'd0, 1'b1, 0);
      run_cfg(d[0], 2'd0, 2'd0, 1'b0, 0);
      run_cfg(d[0], 2'd1, 2'd0, 1'b0, 0);
      run_cfg(d[0], 2'd2, 2'd3, 1'b0, 0);
    end
    // R10: empty queue, reads ignored, flag stays low
    rst_n = 1'b0; wr_w = 2'd0; rd_w = 2'd2; rd_sel = 1'b1; def_sel = 1'b0;
    wait_r(2); rst_n = 1'b1;
    @(negedge rclk); rd_en = 1'b1;
    repeat (5) @(negedge rclk);
    rd_en = 1'b0;
    @(negedge wclk); wr_en = 1'b1;
    repeat (9) @(negedge wclk);
    wr_en = 1'b0;
    wait_r(8); chk("R10", flag, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rclk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule